// File: doc/BRIEF.md
# Reset configuration word capture

This block latches a debug pin configuration from the data bus lanes while the chip is held in power-on or hard reset. It keeps that configuration in a register that software can rewrite, and from it selects what a few shared pins carry. During reset the block re-reads the bus lanes at a fixed interval, but only while the configuration strobe is asserted. The last reading taken before reset is released becomes the power-up configuration. If no reading is ever taken, the configuration is all zeros.

Software may change the two routing fields at any time until it sets a sticky lock bit. A changed routing field does not move any pin by itself. The pins follow the register only at the next soft reset, or at the end of the next hard reset. The freeze-select bit acts at once.

The outputs are plain select levels for the pad logic. One selects the function of the alternate pin group, one selects the function of the test-port pin group, and the rest control the freeze/interrupt pin and the two flush-status pins.

Top module: `rstcfg_capture`

## Requirements
- R1: While `por` or `hard_rst` is high, the outputs show the reset state: `grp_a_dev`=0 (alternate group on its general function), `grp_b_shared`=0 (test-port group carries the test port only) and `frz_is_freeze`=1. The flush pins are off (`flush_en`=0, `flush_val`=00) and the lock is clear. The same state holds after a reset in which no bus reading was taken.
- R2: While reset is held continuously, `cfg_lanes` is read on the 9th, 18th, 27th, ... rising edge of that reset, counting from its first edge, and only if `strap_en` is high on that edge. Each reading replaces the previous one. A reset shorter than 9 edges takes no reading.
- R3: If `strap_en` is low on every reading edge of a reset, the captured word is all zeros. Outside reset, the captured word never changes.
- R4: On the first rising edge with both resets low, the register and the live pin routing load route = `cfg_lanes[3:2]` and location = `cfg_lanes[1:0]` from the captured word, with freeze-select 1 and lock 0.
- R5: A write (`wr_en`=1) uses `wr_data` as {lock[5], freeze-select[4], route[3:2], location[1:0]}. Route and location writes do not change the pins. A cycle with `soft_rst`=1 copies the register's route and location into the live routing. When a write and a soft reset share one edge, the routing takes the value the register held before that write.
- R6: Writing lock=1 sets the lock; the route and location carried by that same write are still stored. Once the lock is set, route and location writes are ignored and the lock cannot be cleared by software. Only a hard or power-on reset clears it.
- R7: The freeze-select bit is written regardless of the lock and drives `frz_is_freeze` from the edge after the write, with no soft reset.
- R8: Live route decode: 00 and 01 give `grp_a_dev` = location[0] and `grp_b_shared`=0. 10 gives `grp_a_dev`=1 and `grp_b_shared`=0. 11 gives `grp_a_dev`=0 and `grp_b_shared`=1, and overrides the location field entirely.
- R9: `flush_en`=1 exactly when the live location is 11 and the route is not 11. When enabled, `flush_val` is 11 if `dbg_active` is high and `flush_status` otherwise; when disabled it is 00. `frz_is_freeze` = freeze-select AND NOT `flush_en`, and `frz_pin_val` = `frz_is_freeze` AND `dbg_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| hard_rst | input | 1 | Hard reset, active high, synchronous |
| strap_en | input | 1 | Configuration strobe: allows bus readings during reset |
| cfg_lanes | input | 4 | Data bus lanes carrying route[3:2] and location[1:0] |
| soft_rst | input | 1 | Soft reset: reapply register routing to the pins |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Register write value {lock, freeze-select, route, location} |
| dbg_active | input | 1 | Core is in debug mode |
| flush_status | input | 2 | Core flush-status code |
| grp_a_dev | output | 1 | 1: alternate pin group carries the development port |
| grp_b_shared | output | 1 | 1: test-port pin group also carries the development port |
| frz_is_freeze | output | 1 | 1: shared pin drives freeze; 0: interrupt input |
| frz_pin_val | output | 1 | Value driven on the freeze pin |
| flush_en | output | 1 | Flush-status pins replace freeze |
| flush_val | output | 2 | Value driven on the flush-status pins |

## Verification
A register write and a soft reset can land on the same clock edge. The bench provokes this by raising `wr_en` and `soft_rst` together, with a route that differs from the stored one. It judges the result by the routing staying at the pre-write value until a later, lone soft reset moves it. A write that sets the lock while also carrying new fields is a second same-edge case. It is judged by those fields appearing on the pins at the next soft reset, while later writes do not. The capture edge is probed at both sides of the boundary: a reset released after 8 edges takes no reading, and one released after 9 edges takes one.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

    // Software-visible configuration register
    typedef struct packed {
        logic       lock;
        logic       frz_keep;
        logic [1:0] route;
        logic [1:0] loc;
    } cfg_reg_t;

    // Live pin routing applied to the pads
    typedef struct packed {
        logic [1:0] route;
        logic [1:0] loc;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        ROUTE_BY_LOC = 2'b00,
        ROUTE_RSVD   = 2'b01,
        ROUTE_TEST   = 2'b10,
        ROUTE_SHARED = 2'b11
    } route_e;

    localparam logic [1:0] LOC_FLUSH = 2'b11;
    localparam logic [1:0] FLUSH_DEBUG_CODE = 2'b11;

    localparam cfg_reg_t CFG_RESET = '{lock: 1'b0, frz_keep: 1'b1, route: 2'b00, loc: 2'b00};

    function automatic pin_cfg_t lanes_to_cfg(input logic [3:0] lanes);
        pin_cfg_t c;
        c.route = lanes[3:2];
        c.loc   = lanes[1:0];
        return c;
    endfunction

    function automatic cfg_reg_t boot_reg(input pin_cfg_t c);
        cfg_reg_t r;
        r.lock     = 1'b0;
        r.frz_keep = 1'b1;
        r.route    = c.route;
        r.loc      = c.loc;
        return r;
    endfunction

endpackage

// File: rtl/rstcfg_sampler.sv
module rstcfg_sampler
    import rstcfg_pkg::*;
#(
    parameter int SAMPLE_EVERY = 9
) (
    input  logic     clk,
    input  logic     por,
    input  logic     hard_rst,
    input  logic     strap_en,
    input  logic [3:0] cfg_lanes,
    output logic     in_reset,
    output logic     rst_exit,
    output pin_cfg_t cap_cfg
);
    localparam int CW   = (SAMPLE_EVERY > 1) ? $clog2(SAMPLE_EVERY) : 1;
    localparam int LAST = SAMPLE_EVERY - 1;

    logic          was_reset;
    logic [CW-1:0] phase;
    logic          sample_hit;
    pin_cfg_t      cap_q;

    assign in_reset   = por | hard_rst;
    assign rst_exit   = !in_reset && was_reset;
    assign sample_hit = in_reset && (phase == CW'(LAST));
    assign cap_cfg    = cap_q;

    always_ff @(posedge clk) begin
        was_reset <= in_reset;
    end

    // Counts edges of a continuous reset, wrapping each interval
    always_ff @(posedge clk) begin
        if (!in_reset)        phase <= '0;
        else if (sample_hit)  phase <= '0;
        else                  phase <= phase + CW'(1);
    end

    // Reset entry clears to the default word; strobed readings replace it
    always_ff @(posedge clk) begin
        if (in_reset && !was_reset)     cap_q <= '0;
        else if (sample_hit && strap_en) cap_q <= lanes_to_cfg(cfg_lanes);
    end

    assert_no_read_without_strap_R2: assert property (@(posedge clk)
        (in_reset && was_reset && !strap_en) |=> $stable(cap_q));

    assert_capture_frozen_outside_R3: assert property (@(posedge clk) disable iff (in_reset)
        !in_reset |=> $stable(cap_q));

endmodule

// File: rtl/rstcfg_creg.sv
module rstcfg_creg
    import rstcfg_pkg::*;
(
    input  logic     clk,
    input  logic     in_reset,
    input  logic     rst_exit,
    input  pin_cfg_t cap_cfg,
    input  logic     soft_rst,
    input  logic     wr_en,
    input  cfg_reg_t wr_val,
    output cfg_reg_t creg,
    output pin_cfg_t live
);
    cfg_reg_t creg_q;
    pin_cfg_t live_q;

    assign creg = creg_q;
    assign live = live_q;

    always_ff @(posedge clk) begin
        if (in_reset) begin
            creg_q <= CFG_RESET;
        end else if (rst_exit) begin
            creg_q <= boot_reg(cap_cfg);
        end else if (wr_en) begin
            creg_q.frz_keep <= wr_val.frz_keep;
            creg_q.lock     <= creg_q.lock | wr_val.lock;
            if (!creg_q.lock) begin
                creg_q.route <= wr_val.route;
                creg_q.loc   <= wr_val.loc;
            end
        end
    end

    // Live routing moves only at reset exit or soft reset
    always_ff @(posedge clk) begin
        if (in_reset)      live_q <= '0;
        else if (rst_exit) live_q <= cap_cfg;
        else if (soft_rst) live_q <= '{route: creg_q.route, loc: creg_q.loc};
    end

    assert_exit_loads_capture_R4: assert property (@(posedge clk) disable iff (in_reset)
        rst_exit |=> (live_q == $past(cap_cfg)) && !creg_q.lock && creg_q.frz_keep);

    assert_soft_copies_register_R5: assert property (@(posedge clk) disable iff (in_reset)
        (soft_rst && !rst_exit) |=> (live_q.route == $past(creg_q.route)) && (live_q.loc == $past(creg_q.loc)));

    assert_live_holds_R5: assert property (@(posedge clk) disable iff (in_reset)
        (!soft_rst && !rst_exit) |=> $stable(live_q));

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (in_reset)
        creg_q.lock |=> creg_q.lock);

    assert_locked_fields_hold_R6: assert property (@(posedge clk) disable iff (in_reset)
        creg_q.lock |=> ($stable(creg_q.route) && $stable(creg_q.loc)));

    assert_freeze_bit_written_R7: assert property (@(posedge clk) disable iff (in_reset)
        (wr_en && !rst_exit) |=> (creg_q.frz_keep == $past(wr_val.frz_keep)));

endmodule

// File: rtl/rstcfg_pinmux.sv
module rstcfg_pinmux
    import rstcfg_pkg::*;
(
    input  logic       clk,
    input  logic       in_reset,
    input  pin_cfg_t   live,
    input  logic       frz_keep,
    input  logic       dbg_active,
    input  logic [1:0] flush_status,
    output logic       grp_a_dev,
    output logic       grp_b_shared,
    output logic       frz_is_freeze,
    output logic       frz_pin_val,
    output logic       flush_en,
    output logic [1:0] flush_val
);
    always_comb begin
        case (route_e'(live.route))
            ROUTE_TEST: begin
                grp_a_dev    = 1'b1;
                grp_b_shared = 1'b0;
            end
            ROUTE_SHARED: begin
                grp_a_dev    = 1'b0;
                grp_b_shared = 1'b1;
            end
            default: begin
                grp_a_dev    = live.loc[0];
                grp_b_shared = 1'b0;
            end
        endcase
        flush_en      = (live.loc == LOC_FLUSH) && (route_e'(live.route) != ROUTE_SHARED);
        frz_is_freeze = frz_keep && !flush_en;
        frz_pin_val   = frz_is_freeze && dbg_active;
        if (!flush_en)       flush_val = 2'b00;
        else if (dbg_active) flush_val = FLUSH_DEBUG_CODE;
        else                 flush_val = flush_status;
    end

    assert_flush_masks_freeze_R9: assert property (@(posedge clk) disable iff (in_reset)
        flush_en |-> !frz_is_freeze);

    assert_debug_code_R9: assert property (@(posedge clk) disable iff (in_reset)
        (flush_en && dbg_active) |-> (flush_val == 2'b11));

    assert_shared_override_R8: assert property (@(posedge clk) disable iff (in_reset)
        (live.route == 2'b11) |-> (!flush_en && grp_b_shared && !grp_a_dev));

endmodule

// File: rtl/rstcfg_capture.sv
module rstcfg_capture
    import rstcfg_pkg::*;
#(
    parameter int SAMPLE_EVERY = 9
) (
    input  logic       clk,
    input  logic       por,
    input  logic       hard_rst,
    input  logic       strap_en,
    input  logic [3:0] cfg_lanes,
    input  logic       soft_rst,
    input  logic       wr_en,
    input  logic [5:0] wr_data,
    input  logic       dbg_active,
    input  logic [1:0] flush_status,
    output logic       grp_a_dev,
    output logic       grp_b_shared,
    output logic       frz_is_freeze,
    output logic       frz_pin_val,
    output logic       flush_en,
    output logic [1:0] flush_val
);
    logic     in_reset;
    logic     rst_exit;
    pin_cfg_t cap_cfg;
    cfg_reg_t creg;
    pin_cfg_t live;

    rstcfg_sampler #(.SAMPLE_EVERY(SAMPLE_EVERY)) u_sampler (
        .clk       (clk),
        .por       (por),
        .hard_rst  (hard_rst),
        .strap_en  (strap_en),
        .cfg_lanes (cfg_lanes),
        .in_reset  (in_reset),
        .rst_exit  (rst_exit),
        .cap_cfg   (cap_cfg)
    );

    rstcfg_creg u_creg (
        .clk      (clk),
        .in_reset (in_reset),
        .rst_exit (rst_exit),
        .cap_cfg  (cap_cfg),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_val   (cfg_reg_t'(wr_data)),
        .creg     (creg),
        .live     (live)
    );

    rstcfg_pinmux u_pinmux (
        .clk           (clk),
        .in_reset      (in_reset),
        .live          (live),
        .frz_keep      (creg.frz_keep),
        .dbg_active    (dbg_active),
        .flush_status  (flush_status),
        .grp_a_dev     (grp_a_dev),
        .grp_b_shared  (grp_b_shared),
        .frz_is_freeze (frz_is_freeze),
        .frz_pin_val   (frz_pin_val),
        .flush_en      (flush_en),
        .flush_val     (flush_val)
    );

endmodule

// File: tb/rstcfg_capture_tb.sv
module rstcfg_capture_tb;
    logic       clk = 1'b0;
    logic       por = 1'b0;
    logic       hard_rst = 1'b0;
    logic       strap_en = 1'b0;
    logic [3:0] cfg_lanes = '0;
    logic       soft_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       dbg_active = 1'b0;
    logic [1:0] flush_status = '0;
    logic       grp_a_dev, grp_b_shared, frz_is_freeze, frz_pin_val, flush_en;
    logic [1:0] flush_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rstcfg_capture u_dut (
        .clk(clk), .por(por), .hard_rst(hard_rst), .strap_en(strap_en),
        .cfg_lanes(cfg_lanes), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
        .dbg_active(dbg_active), .flush_status(flush_status),
        .grp_a_dev(grp_a_dev), .grp_b_shared(grp_b_shared), .frz_is_freeze(frz_is_freeze),
        .frz_pin_val(frz_pin_val), .flush_en(flush_en), .flush_val(flush_val)
    );

    // Stimulus {route, loc, dbg_active, flush_status} and expected
    // {grp_a_dev, grp_b_shared, frz_is_freeze, frz_pin_val, flush_en, flush_val}
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        14'b00_00_1_01_0_0_1_1_0_00,
        14'b00_01_0_10_1_0_1_0_0_00,
        14'b00_11_0_10_1_0_0_0_1_10,
        14'b00_11_1_01_1_0_0_0_1_11,
        14'b01_01_1_00_1_0_1_1_0_00,
        14'b10_00_1_11_1_0_1_1_0_00,
        14'b10_11_0_01_1_0_0_0_1_01,
        14'b11_11_1_10_0_1_1_1_0_00,
        14'b11_01_0_00_0_1_1_0_0_00,
        14'b01_10_1_11_0_0_1_1_0_00
    };

    localparam logic [6:0] EXP_DEFAULT = 7'b0_0_1_0_0_00;

    task automatic check(input string tag, input logic [6:0] exp);
        logic [6:0] got;
        #1;
        got = {grp_a_dev, grp_b_shared, frz_is_freeze, frz_pin_val, flush_en, flush_val};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic lk, input logic fz, input logic [1:0] rt,
                            input logic [1:0] lc, input logic with_soft);
        wr_data  = {lk, fz, rt, lc};
        wr_en    = 1'b1;
        soft_rst = with_soft;
        @(negedge clk);
        wr_en    = 1'b0;
        soft_rst = 1'b0;
    endtask

    task automatic do_soft();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic hold_reset(input int edges);
        hard_rst = 1'b1;
        repeat (edges) @(negedge clk);
        hard_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);

        // R1: power-on reset without strobe
        por = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 during power-on reset", EXP_DEFAULT);
        repeat (7) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        check("R1 R3 after power-on, no reading", EXP_DEFAULT);

        // R8 R9: decode table walked through write + soft reset
        for (int i = 0; i < NV; i++) begin
            do_write(1'b0, 1'b1, VEC[i][13:12], VEC[i][11:10], 1'b0);
            do_soft();
            dbg_active   = VEC[i][9];
            flush_status = VEC[i][8:7];
            check($sformatf("R8 R9 vector %0d", i), VEC[i][6:0]);
        end
        dbg_active   = 1'b0;
        flush_status = 2'b00;

        // R1: entering reset returns outputs to default
        hard_rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during hard reset", EXP_DEFAULT);
        repeat (3) @(negedge clk);
        hard_rst = 1'b0;
        @(negedge clk);

        // R2: 8-edge reset takes no reading
        strap_en  = 1'b1;
        cfg_lanes = 4'b11_01;
        hold_reset(8);
        check("R2 R3 reset of 8 edges, no reading", EXP_DEFAULT);

        // R2 R4: exactly 9 edges takes one reading
        hold_reset(9);
        check("R2 R4 reset of 9 edges, route 11", 7'b0_1_1_0_0_00);

        // R2: later reading replaces earlier one; value after last reading ignored
        hard_rst  = 1'b1;
        cfg_lanes = 4'b11_01;
        repeat (9) @(negedge clk);
        cfg_lanes = 4'b10_01;
        repeat (9) @(negedge clk);
        cfg_lanes = 4'b00_11;
        repeat (2) @(negedge clk);
        hard_rst  = 1'b0;
        @(negedge clk);
        check("R2 R4 second reading kept", 7'b1_0_1_0_0_00);

        // R2: reading with strobe low is skipped
        hard_rst  = 1'b1;
        strap_en  = 1'b1;
        cfg_lanes = 4'b11_01;
        repeat (9) @(negedge clk);
        strap_en  = 1'b0;
        cfg_lanes = 4'b10_01;
        repeat (9) @(negedge clk);
        hard_rst  = 1'b0;
        @(negedge clk);
        check("R2 strobe low on second reading", 7'b0_1_1_0_0_00);

        // R3: strobe never high gives zero word
        cfg_lanes = 4'b10_11;
        hold_reset(20);
        check("R3 no strobe gives zero word", EXP_DEFAULT);

        // R5: write alone does not move pins
        do_write(1'b0, 1'b1, 2'b10, 2'b00, 1'b0);
        check("R5 write without soft reset", EXP_DEFAULT);
        do_soft();
        check("R5 soft reset applies register", 7'b1_0_1_0_0_00);

        // R5: write and soft reset on the same edge
        do_write(1'b0, 1'b1, 2'b11, 2'b00, 1'b1);
        check("R5 same-edge write and soft reset", 7'b1_0_1_0_0_00);
        do_soft();
        check("R5 later soft reset applies new value", 7'b0_1_1_0_0_00);

        // R7: freeze-select acts without soft reset
        do_write(1'b0, 1'b0, 2'b11, 2'b00, 1'b0);
        check("R7 freeze-select cleared", 7'b0_1_0_0_0_00);
        do_write(1'b0, 1'b1, 2'b11, 2'b00, 1'b0);
        dbg_active = 1'b1;
        check("R7 freeze-select set, debug active", 7'b0_1_1_1_0_00);
        dbg_active = 1'b0;

        // R6: locking write still stores its fields
        do_write(1'b1, 1'b1, 2'b10, 2'b00, 1'b0);
        do_soft();
        check("R6 locking write stores fields", 7'b1_0_1_0_0_00);
        do_write(1'b0, 1'b1, 2'b11, 2'b11, 1'b0);
        do_soft();
        check("R6 locked fields ignore write", 7'b1_0_1_0_0_00);
        do_write(1'b0, 1'b0, 2'b11, 2'b00, 1'b0);
        check("R7 freeze-select written while locked", 7'b1_0_0_0_0_00);
        do_soft();
        check("R6 lock not cleared by write", 7'b1_0_0_0_0_00);

        // R6: hard reset clears lock
        strap_en = 1'b0;
        hold_reset(3);
        check("R1 R6 hard reset restores default", EXP_DEFAULT);
        do_write(1'b0, 1'b1, 2'b11, 2'b00, 1'b0);
        do_soft();
        check("R6 write accepted after hard reset", 7'b0_1_1_0_0_00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule